// File: doc/BRIEF.md
# Dual-Master Hardware Semaphore Bank

This block holds a small bank of hardware locks shared by a host processor and a coprocessor that run concurrent threads. Each lock is in one of three conditions: free, held by the host, or held by the coprocessor. A thread takes a lock before it enters a critical section that touches a shared resource, and gives it back when it leaves. The bank guarantees that only one of the two masters holds a given lock at any time.

The host reaches the bank through one 16-bit register. The upper byte is a per-lock write mask and the lower byte carries the requested value, so one write can take or release any subset of locks and leave the others untouched. Reading the register shows which locks the host itself holds. A host therefore takes a lock in two steps: it writes the request, then reads back to see whether the request succeeded. The coprocessor issues set or clear commands that carry a lock index. A set command returns a success flag one cycle later.

A release only takes effect when it comes from the master that currently holds the lock. When both masters try to take the same free lock in the same cycle, the coprocessor wins.

Top module: `dual_lock_bank`

## Requirements
- R1: A synchronous active-high reset frees every lock. After reset, `hostRdData` reads 0 and `cpSetOk` is 0. A host write of 16'hFFFF then takes all eight locks.
- R2: A host write with mask bit n+8 = 1 and data bit n = 1 takes lock n if it is free. From the next cycle, bit n of `hostRdData` reads 1.
- R3: In a host write, every lock whose mask bit (bit n+8) is 0 keeps its condition, whatever its data bit is.
- R4: A host write with mask bit n+8 = 1 and data bit n = 0 frees lock n only if the host holds it. A lock held by the coprocessor stays held by the coprocessor.
- R5: A coprocessor set command (`cpSetReq` = 1, index `cpIdx`) on a free lock gives that lock to the coprocessor. In the next cycle `cpSetOk` is 1.
- R6: A coprocessor set command on a lock held by the host leaves the lock unchanged, and `cpSetOk` is 0 in the next cycle. A set command on a lock the coprocessor already holds gives `cpSetOk` = 1 and leaves the lock unchanged.
- R7: A coprocessor clear command (`cpClrReq` = 1) frees the indexed lock only if the coprocessor holds it. It has no effect on a lock held by the host or on a free lock.
- R8: A host set on a lock held by the coprocessor has no effect. Bit n of `hostRdData` stays 0 and the lock stays with the coprocessor.
- R9: When a host set and a coprocessor set target the same free lock in the same cycle, the coprocessor takes the lock, `cpSetOk` is 1, and the host read bit stays 0.
- R10: `cpSetOk` is a one-cycle flag. It is 0 in every cycle that does not follow a coprocessor set command.
- R11: Bits 15:8 of `hostRdData` always read 0.
- R12: When `cpSetReq` and `cpClrReq` are both 1 in the same cycle, the command acts as a set only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostWrData | input | 16 | Mask in 15:8, requested values in 7:0 |
| hostRdData | output | 16 | Bit n is 1 when the host holds lock n; 15:8 read 0 |
| cpSetReq | input | 1 | Coprocessor set-lock command |
| cpClrReq | input | 1 | Coprocessor clear-lock command |
| cpIdx | input | 3 | Lock index of the coprocessor command |
| cpSetOk | output | 1 | Success flag, one cycle after a set command |

## Verification
- **Host-held locks:** a wrong condition for a lock held by the host shows on `hostRdData` in the cycle after the write that caused it.
- **Coprocessor set result:** a wrong outcome of a coprocessor set shows on `cpSetOk` one cycle after the command.
- **Free versus coprocessor-held:** the host read shows these two conditions the same way, so a fault between them stays hidden until a later access. The bench probes each lock with a host set after every operation, which exposes such a fault within one cycle.
- **Sweep coverage:** the sweep covers every lock and every starting condition against every command, including same-cycle contention.

// File: rtl/sem_pkg.sv
package sem_pkg;

  typedef enum logic [1:0] {
    SEM_FREE   = 2'd0,
    SEM_HOST   = 2'd1,
    SEM_COPROC = 2'd2
  } semState_e;

  // Per-lock strobes from control to datapath
  typedef struct packed {
    logic hostSet;
    logic hostClr;
    logic cpSet;
    logic cpClr;
  } semStrobe_t;

endpackage

// File: rtl/sem_ctrl.sv
module sem_ctrl
  import sem_pkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int IDX_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       hostWrEn,
  input  logic [2*NUM_SEM-1:0]       hostWrData,
  input  logic                       cpSetReq,
  input  logic                       cpClrReq,
  input  logic [IDX_W-1:0]           cpIdx,
  input  logic [NUM_SEM-1:0]         hostOwned,
  output semStrobe_t [NUM_SEM-1:0]   strobes,
  output logic                       cpSetOk
);

  logic [NUM_SEM-1:0] maskField;
  logic [NUM_SEM-1:0] dataField;
  logic               idxValid;
  logic               hostHoldsIdx;

  assign maskField = hostWrData[2*NUM_SEM-1:NUM_SEM];
  assign dataField = hostWrData[NUM_SEM-1:0];
  assign idxValid  = (int'(cpIdx) < NUM_SEM);

  always_comb begin
    hostHoldsIdx = 1'b0;
    for (int k = 0; k < NUM_SEM; k++) begin
      if (int'(cpIdx) == k) hostHoldsIdx = hostOwned[k];
    end
  end

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_decode
    logic cpHit;
    assign cpHit = (cpIdx == IDX_W'(g));
    assign strobes[g].hostSet = hostWrEn & maskField[g] & dataField[g];
    assign strobes[g].hostClr = hostWrEn & maskField[g] & ~dataField[g];
    assign strobes[g].cpSet   = cpSetReq & cpHit;
    assign strobes[g].cpClr   = cpClrReq & ~cpSetReq & cpHit;
  end

  always_ff @(posedge clk) begin
    if (rst) cpSetOk <= 1'b0;
    else     cpSetOk <= cpSetReq & idxValid & ~hostHoldsIdx;
  end

endmodule

// File: rtl/sem_datapath.sv
module sem_datapath
  import sem_pkg::*;
#(
  parameter int NUM_SEM = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  semStrobe_t [NUM_SEM-1:0] strobes,
  output logic [NUM_SEM-1:0]       hostOwned,
  output logic [NUM_SEM-1:0]       cpOwned
);

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_sem
    semState_e semState;

    always_ff @(posedge clk) begin
      if (rst) begin
        semState <= SEM_FREE;
      end else begin
        unique case (semState)
          SEM_FREE: begin
            if (strobes[g].cpSet)        semState <= SEM_COPROC;
            else if (strobes[g].hostSet) semState <= SEM_HOST;
          end
          SEM_HOST: begin
            if (strobes[g].hostClr) semState <= SEM_FREE;
          end
          SEM_COPROC: begin
            if (strobes[g].cpClr) semState <= SEM_FREE;
          end
          default: semState <= SEM_FREE;
        endcase
      end
    end

    assign hostOwned[g] = (semState == SEM_HOST);
    assign cpOwned[g]   = (semState == SEM_COPROC);
  end

endmodule

// File: rtl/dual_lock_bank.sv
module dual_lock_bank
  import sem_pkg::*;
#(
  parameter int NUM_SEM = 8,
  localparam int REG_W = 2 * NUM_SEM,
  localparam int IDX_W = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hostWrEn,
  input  logic [REG_W-1:0] hostWrData,
  output logic [REG_W-1:0] hostRdData,
  input  logic             cpSetReq,
  input  logic             cpClrReq,
  input  logic [IDX_W-1:0] cpIdx,
  output logic             cpSetOk
);

  semStrobe_t [NUM_SEM-1:0] strobes;
  logic [NUM_SEM-1:0]       hostOwned;
  logic [NUM_SEM-1:0]       cpOwned;

  sem_ctrl #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .hostWrEn   (hostWrEn),
    .hostWrData (hostWrData),
    .cpSetReq   (cpSetReq),
    .cpClrReq   (cpClrReq),
    .cpIdx      (cpIdx),
    .hostOwned  (hostOwned),
    .strobes    (strobes),
    .cpSetOk    (cpSetOk)
  );

  sem_datapath #(.NUM_SEM(NUM_SEM)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .hostOwned (hostOwned),
    .cpOwned   (cpOwned)
  );

  assign hostRdData = {{NUM_SEM{1'b0}}, hostOwned};

endmodule

// File: rtl/dual_lock_bank_chk.sv
module dual_lock_bank_chk #(
  parameter int NUM_SEM = 8,
  localparam int REG_W = 2 * NUM_SEM,
  localparam int IDX_W = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             hostWrEn,
  input logic [REG_W-1:0] hostWrData,
  input logic [REG_W-1:0] hostRdData,
  input logic             cpSetReq,
  input logic             cpClrReq,
  input logic [IDX_W-1:0] cpIdx,
  input logic             cpSetOk,
  input logic [NUM_SEM-1:0] cpOwned
);

  // R10: flag only follows a set command
  p_ok_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    !cpSetReq |=> !cpSetOk);

  // R11: mask half of the readback is always zero
  p_upper_zero_r11: assert property (@(posedge clk) disable iff (rst)
    hostRdData[REG_W-1:NUM_SEM] == '0);

  // R7: coprocessor commands never alter what the host holds
  p_host_stable_r7: assert property (@(posedge clk) disable iff (rst)
    !hostWrEn |=> $stable(hostRdData));

  // R6: set on a host-held lock fails
  p_cp_fail_r6: assert property (@(posedge clk) disable iff (rst)
    cpSetReq && hostRdData[cpIdx] |=> !cpSetOk);

  // R9: coprocessor set on a free lock wins
  p_cp_win_r9: assert property (@(posedge clk) disable iff (rst)
    cpSetReq && !hostRdData[cpIdx] && !cpOwned[cpIdx]
      |=> cpSetOk && cpOwned[$past(cpIdx)] && !hostRdData[$past(cpIdx)]);

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_lock
    logic cpTargets;
    assign cpTargets = (cpSetReq || cpClrReq) && (cpIdx == IDX_W'(g));

    // R2: host takes a free lock it asks for
    p_host_take_r2: assert property (@(posedge clk) disable iff (rst)
      hostWrEn && hostWrData[NUM_SEM+g] && hostWrData[g] &&
      !cpOwned[g] && !cpTargets |=> hostRdData[g]);

    // R4: host releases a lock it holds
    p_host_free_r4: assert property (@(posedge clk) disable iff (rst)
      hostWrEn && hostWrData[NUM_SEM+g] && !hostWrData[g] && hostRdData[g]
      |=> !hostRdData[g] && !cpOwned[g]);

    // R8: coprocessor keeps its lock until it clears it
    p_cp_keep_r8: assert property (@(posedge clk) disable iff (rst)
      cpOwned[g] && !(cpClrReq && !cpSetReq && cpIdx == IDX_W'(g))
      |=> cpOwned[g] && !hostRdData[g]);

    // R3: unmasked host-held bit keeps its value without coprocessor target
    p_mask_hold_r3: assert property (@(posedge clk) disable iff (rst)
      hostWrEn && !hostWrData[NUM_SEM+g] && !cpTargets
      |=> $stable(hostRdData[g]) && $stable(cpOwned[g]));
  end

endmodule

bind dual_lock_bank dual_lock_bank_chk #(.NUM_SEM(NUM_SEM)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .hostWrEn   (hostWrEn),
  .hostWrData (hostWrData),
  .hostRdData (hostRdData),
  .cpSetReq   (cpSetReq),
  .cpClrReq   (cpClrReq),
  .cpIdx      (cpIdx),
  .cpSetOk    (cpSetOk),
  .cpOwned    (cpOwned)
);

// File: tb/dual_lock_bank_tb.sv
module dual_lock_bank_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_SEM    = 8;
  localparam int REG_W      = 2 * NUM_SEM;
  localparam int IDX_W      = 3;
  localparam int WATCHDOG   = 50000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             hostWrEn = 1'b0;
  logic [REG_W-1:0] hostWrData = '0;
  logic [REG_W-1:0] hostRdData;
  logic             cpSetReq = 1'b0;
  logic             cpClrReq = 1'b0;
  logic [IDX_W-1:0] cpIdx = '0;
  logic             cpSetOk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // model: 0 free, 1 host, 2 coprocessor
  int model [NUM_SEM];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_lock_bank #(.NUM_SEM(NUM_SEM)) u_dut (
    .clk(clk), .rst(rst), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .cpSetReq(cpSetReq), .cpClrReq(cpClrReq),
    .cpIdx(cpIdx), .cpSetOk(cpSetOk)
  );

  task automatic chk(input bit ok, input string tag, input logic [REG_W-1:0] act,
                     input logic [REG_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [REG_W-1:0] expRead();
    logic [REG_W-1:0] r = '0;
    for (int k = 0; k < NUM_SEM; k++) r[k] = (model[k] == 1);
    return r;
  endfunction

  // drive at negedge, compare at the following negedge
  task automatic step(input logic hw, input logic [REG_W-1:0] wd, input logic cs,
                      input logic cc, input int ix, input string tag);
    logic expOk;
    hostWrEn = hw; hostWrData = wd; cpSetReq = cs; cpClrReq = cc;
    cpIdx = IDX_W'(ix);
    expOk = cs && (model[ix] != 1);
    for (int k = 0; k < NUM_SEM; k++) begin
      bit cS, cC, hS, hC;
      cS = cs && (ix == k);
      cC = cc && !cs && (ix == k);
      hS = hw && wd[NUM_SEM+k] && wd[k];
      hC = hw && wd[NUM_SEM+k] && !wd[k];
      case (model[k])
        0: if (cS) model[k] = 2; else if (hS) model[k] = 1;
        1: if (hC) model[k] = 0;
        default: if (cC) model[k] = 0;
      endcase
    end
    @(negedge clk);
    chk(hostRdData[NUM_SEM-1:0] == expRead()[NUM_SEM-1:0], {tag, " read"},
        hostRdData, expRead());
    chk(hostRdData[REG_W-1:NUM_SEM] == '0, "R11 upper", hostRdData, '0);
    chk(cpSetOk == expOk, {tag, " cpSetOk"}, REG_W'(cpSetOk), REG_W'(expOk));
    hostWrEn = 1'b0; cpSetReq = 1'b0; cpClrReq = 1'b0;
  endtask

  function automatic logic [REG_W-1:0] hw1(input int i, input bit v);
    logic [REG_W-1:0] w = '0;
    w[NUM_SEM+i] = 1'b1;
    w[i] = v;
    return w;
  endfunction

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] lfsr;
    for (int k = 0; k < NUM_SEM; k++) model[k] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(hostRdData == '0, "R1 reset read", hostRdData, '0);
    chk(cpSetOk == 1'b0, "R1 reset flag", REG_W'(cpSetOk), '0);
    step(1'b1, 16'hFFFF, 1'b0, 1'b0, 0, "R1 take all");
    step(1'b1, 16'hFF00, 1'b0, 1'b0, 0, "R4 free all");

    // exhaustive: lock x starting condition x operation
    for (int i = 0; i < NUM_SEM; i++) begin
      for (int init = 0; init < 3; init++) begin
        for (int op = 0; op < 7; op++) begin
          step(1'b1, hw1(i, 1'b0), 1'b0, 1'b0, i, "R4 setup");
          step(1'b0, '0, 1'b0, 1'b1, i, "R7 setup");
          if (init == 1) step(1'b1, hw1(i, 1'b1), 1'b0, 1'b0, i, "R2 init");
          if (init == 2) step(1'b0, '0, 1'b1, 1'b0, i, "R5 init");
          case (op)
            0: step(1'b1, hw1(i, 1'b1), 1'b0, 1'b0, i, (init == 2) ? "R8" : "R2");
            1: step(1'b1, hw1(i, 1'b0), 1'b0, 1'b0, i, "R4");
            2: step(1'b0, '0, 1'b1, 1'b0, i, (init == 1) ? "R6" : "R5");
            3: step(1'b0, '0, 1'b0, 1'b1, i, "R7");
            4: step(1'b1, hw1(i, 1'b1), 1'b1, 1'b0, i, "R9");
            5: step(1'b0, '0, 1'b1, 1'b1, i, "R12");
            default: begin
              logic [REG_W-1:0] w;
              w = {~hw1(i, 1'b0)[REG_W-1:NUM_SEM], {NUM_SEM{1'b1}}};
              step(1'b1, w, 1'b0, 1'b0, i, "R3");
              step(1'b1, {~hw1(i, 1'b0)[REG_W-1:NUM_SEM], {NUM_SEM{1'b0}}},
                   1'b0, 1'b0, i, "R3 restore");
            end
          endcase
          step(1'b0, '0, 1'b0, 1'b0, i, "R10 idle");
          step(1'b1, hw1(i, 1'b1), 1'b0, 1'b0, i, "R8 probe");
        end
      end
    end

    // pseudo-random mixed traffic
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], {lfsr[15:8], lfsr[7:0] ^ lfsr[15:8]}, lfsr[1] & lfsr[4],
           lfsr[2] & lfsr[5], int'(lfsr[10:8]), "R5 R2 sweep");
    end

    // reset in the middle of activity
    step(1'b0, '0, 1'b1, 1'b0, 3, "R5 pre-reset");
    step(1'b1, 16'hFFFF, 1'b0, 1'b0, 0, "R2 pre-reset");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < NUM_SEM; k++) model[k] = 0;
    chk(hostRdData == '0, "R1 mid reset read", hostRdData, '0);
    chk(cpSetOk == 1'b0, "R1 mid reset flag", REG_W'(cpSetOk), '0);
    step(1'b1, 16'hFFFF, 1'b0, 1'b0, 0, "R1 take all after reset");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule